// File: doc/BRIEF.md
# I2C Setpoint Slave for a Current-Sink DAC

This block is the digital front end of a 10-bit current-sink DAC. It listens on a two-wire bus as a slave. The SCL and SDA inputs are oversampled with the system clock, and the block removes short spikes from both lines. It then finds start and stop conditions and shifts in an address byte followed by two setpoint bytes. When a complete frame has arrived, the block loads a DAC code register and a software power-down flag. A master can also read the 16-bit input register back. Once that read completes, the input register is zeroed.

The output side produces the code for the analog stage and an enable for the sink. The enable combines three things: whether a frame has been accepted since reset, the software power-down flag, and an active-low shutdown pin. The shutdown pin acts without waiting for a clock edge. The open-drain pad sits outside the block, so the slave's SDA output is a single drive-low enable.

Top module: `i2c_dac_ctrl`

## Requirements
- R1: After reset, `sink_en_o` is 0, `sink_code_o` is 0, `soft_pd_o` is 0 and `sda_pull_o` is 0. The enable stays 0 until the first complete write frame.
- R2: An address byte selects the block when its bits 7..3 equal 00011. Bits 2..1 are don't-care, so write bytes 0x18, 0x1A, 0x1C and 0x1E all select it. Bit 0 is the direction, with 1 meaning read. On a match, the block pulls SDA low during the ninth clock.
- R3: An address byte that does not match gets no acknowledge. The block then leaves SDA released and ignores all traffic until the next start.
- R4: A write frame carries two data bytes, high byte first and each byte MSB first. Both bytes are acknowledged. Frame bit 15 is the software power-down (active high) and frame bits 13..4 form the DAC code. Bits 14 and 3..0 have no effect. The code register changes only after the sixteenth data bit.
- R5: A start or a stop that arrives before the sixteenth data bit leaves the DAC code and power-down flag unchanged. A start always restarts the address phase.
- R6: A read returns the input register as two bytes, high byte first and MSB first. After the second byte has been clocked out, the input register reads as 0x0000. A read never changes the DAC code.
- R7: A NACK from the master after the first read byte returns the block to idle, with SDA released and the input register not cleared.
- R8: `sink_en_o` is 1 only when a frame has been accepted, the power-down flag is 0 and `shdn_n_i` is 1. `sink_code_o` equals the code register while enabled and is 0 otherwise.
- R9: Driving `shdn_n_i` low forces `sink_en_o` and `sink_code_o` to 0 with no clock edge. The stored code is kept and reappears when the pin returns high.
- R10: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system clocks has no effect on the received data.
- R11: Data bytes beyond the second in a write frame are not acknowledged and do not change the DAC code.
- R12: `sda_pull_o` changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low through the pad |
| shdn_n_i | input | 1 | Active-low shutdown, acts without a clock |
| sink_en_o | output | 1 | Enable for the current sink |
| sink_code_o | output | 10 | Gated DAC code for the analog stage |
| soft_pd_o | output | 1 | Software power-down flag from the last frame |

## Verification
The hardest conditions to reach from the ports are those in which bus events land in unusual places. One is a start or stop partway through a byte. Another is a clock spike inside a bit's low phase, which would add a phantom bit if it got through the filter. The bench's bus master is written in per-bit steps, so a scenario can stop after any number of bits and then issue a start or stop. The same master can insert a short SCL pulse into every low phase of a complete frame, and the resulting code shows whether any bit was miscounted. A read that ends with a NACK after the first byte is followed by a second, full read. That second read shows whether the input register survived the short read.

// File: rtl/i2c_dac_pkg.sv
package i2c_dac_pkg;
  localparam int FRAME_W  = 16;
  localparam int CODE_W   = 10;
  localparam int CODE_LSB = 4;
  localparam int PD_POS   = 15;
  localparam int BYTE_W   = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_WRITE = 2'd2,
    ST_READ  = 2'd3
  } slv_state_e;
endpackage

// File: rtl/i2c_spike_filter.sv
module i2c_spike_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CNT_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       run_q;
  logic                   level_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];
  assign dout   = level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
  end

  // Output follows only after FILT_LEN consecutive disagreeing samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      level_q <= 1'b1;
    end else if (synced == level_q) begin
      run_q <= '0;
    end else if (run_q == CNT_W'(FILT_LEN - 1)) begin
      run_q   <= '0;
      level_q <= synced;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  assign scl_rise = scl & ~scl_d;
  assign scl_fall = ~scl & scl_d;
  assign start_ev = scl & scl_d & sda_d & ~sda;
  assign stop_ev  = scl & scl_d & ~sda_d & sda;
endmodule

// File: rtl/i2c_dac_slave.sv
module i2c_dac_slave
  import i2c_dac_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h0C,
  parameter int         IGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_lvl,
  output logic              sda_pull,
  output logic              commit,
  output logic              frame_pd,
  output logic [CODE_W-1:0] frame_code,
  output logic              idle
);
  localparam int CMP_W = 7 - IGN_BITS;

  slv_state_e         state_q;
  logic [3:0]         bit_q;
  logic [1:0]         byte_q;
  logic [6:0]         shreg_q;
  logic [BYTE_W-1:0]  hi_hold_q;
  logic [FRAME_W-1:0] in_reg_q;
  logic               ack_q;
  logic               rw_q;
  logic               drive_q;
  logic               commit_q;
  logic [BYTE_W-1:0]  byte_now;
  logic [BYTE_W-1:0]  rd_byte;
  logic               addr_hit;

  assign byte_now   = {shreg_q, sda_lvl};
  assign rd_byte    = byte_q[0] ? in_reg_q[BYTE_W-1:0] : in_reg_q[FRAME_W-1:BYTE_W];
  assign addr_hit   = (byte_now[7 -: CMP_W] == DEV_ADDR[6 -: CMP_W]);
  assign sda_pull   = drive_q;
  assign commit     = commit_q;
  assign frame_pd   = in_reg_q[PD_POS];
  assign frame_code = in_reg_q[CODE_LSB +: CODE_W];
  assign idle       = (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      byte_q    <= '0;
      shreg_q   <= '0;
      hi_hold_q <= '0;
      in_reg_q  <= '0;
      ack_q     <= 1'b0;
      rw_q      <= 1'b0;
      drive_q   <= 1'b0;
      commit_q  <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (start_ev) begin
        state_q <= ST_ADDR;
        bit_q   <= '0;
        byte_q  <= '0;
        ack_q   <= 1'b0;
        drive_q <= 1'b0;
      end else if (stop_ev) begin
        state_q <= ST_IDLE;
        ack_q   <= 1'b0;
        drive_q <= 1'b0;
      end else begin
        if (scl_rise && state_q != ST_IDLE) begin
          if (bit_q == 4'd8) begin
            // acknowledge clock
            bit_q <= '0;
            ack_q <= 1'b0;
            case (state_q)
              ST_ADDR:  state_q <= rw_q ? ST_READ : ST_WRITE;
              ST_WRITE: if (byte_q != 2'd2) byte_q <= byte_q + 2'd1;
              ST_READ: begin
                if (byte_q == 2'd1) begin
                  in_reg_q <= '0;
                  state_q  <= ST_IDLE;
                  drive_q  <= 1'b0;
                end else if (sda_lvl) begin
                  state_q <= ST_IDLE;
                  drive_q <= 1'b0;
                end else begin
                  byte_q <= 2'd1;
                end
              end
              default: state_q <= ST_IDLE;
            endcase
          end else begin
            bit_q   <= bit_q + 4'd1;
            shreg_q <= byte_now[6:0];
            if (bit_q == 4'd7) begin
              case (state_q)
                ST_ADDR: begin
                  if (addr_hit) begin
                    ack_q <= 1'b1;
                    rw_q  <= byte_now[0];
                  end else begin
                    state_q <= ST_IDLE;
                    drive_q <= 1'b0;
                  end
                end
                ST_WRITE: begin
                  if (byte_q == 2'd0) begin
                    hi_hold_q <= byte_now;
                    ack_q     <= 1'b1;
                  end else if (byte_q == 2'd1) begin
                    in_reg_q <= {hi_hold_q, byte_now};
                    commit_q <= 1'b1;
                    ack_q    <= 1'b1;
                  end
                end
                default: ;
              endcase
            end
          end
        end
        if (scl_fall && state_q != ST_IDLE) begin
          if (state_q == ST_READ && bit_q != 4'd8)
            drive_q <= ~rd_byte[3'd7 - bit_q[2:0]];
          else
            drive_q <= (bit_q == 4'd8) && ack_q;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_dac_outreg.sv
module i2c_dac_outreg
  import i2c_dac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              frame_pd,
  input  logic [CODE_W-1:0] frame_code,
  input  logic              shdn_n,
  output logic [CODE_W-1:0] code_hold,
  output logic              armed,
  output logic              soft_pd,
  output logic              sink_en,
  output logic [CODE_W-1:0] sink_code
);
  logic [CODE_W-1:0] code_q;
  logic              pd_q;
  logic              armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      pd_q    <= 1'b0;
      armed_q <= 1'b0;
    end else if (commit) begin
      code_q  <= frame_code;
      pd_q    <= frame_pd;
      armed_q <= 1'b1;
    end
  end

  // shutdown pin gates combinationally: no clock needed
  assign sink_en   = armed_q & ~pd_q & shdn_n;
  assign sink_code = sink_en ? code_q : '0;
  assign code_hold = code_q;
  assign armed     = armed_q;
  assign soft_pd   = pd_q;
endmodule

// File: rtl/i2c_dac_ctrl.sv
module i2c_dac_ctrl
  import i2c_dac_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter logic [6:0] DEV_ADDR    = 7'h0C,
  parameter int         IGN_BITS    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              shdn_n_i,
  output logic              sink_en_o,
  output logic [CODE_W-1:0] sink_code_o,
  output logic              soft_pd_o
);
  logic [1:0]        raw_lines;
  logic [1:0]        filt_lines;
  logic              scl_lvl, sda_lvl;
  logic              scl_rise, scl_fall, start_ev, stop_ev;
  logic              commit, frame_pd, idle, armed;
  logic [CODE_W-1:0] frame_code, code_hold;

  assign raw_lines = {scl_i, sda_i};
  assign scl_lvl   = filt_lines[1];
  assign sda_lvl   = filt_lines[0];

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_spike_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk (clk),
      .rst_n(rst_n),
      .din (raw_lines[g]),
      .dout(filt_lines[g])
    );
  end

  i2c_line_events u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl     (scl_lvl),
    .sda     (sda_lvl),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  i2c_dac_slave #(
    .DEV_ADDR(DEV_ADDR),
    .IGN_BITS(IGN_BITS)
  ) u_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_lvl   (sda_lvl),
    .sda_pull  (sda_pull_o),
    .commit    (commit),
    .frame_pd  (frame_pd),
    .frame_code(frame_code),
    .idle      (idle)
  );

  i2c_dac_outreg u_outreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .frame_pd  (frame_pd),
    .frame_code(frame_code),
    .shdn_n    (shdn_n_i),
    .code_hold (code_hold),
    .armed     (armed),
    .soft_pd   (soft_pd_o),
    .sink_en   (sink_en_o),
    .sink_code (sink_code_o)
  );
endmodule

// File: rtl/i2c_dac_ctrl_chk.sv
module i2c_dac_ctrl_chk
  import i2c_dac_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              sda_pull_o,
  input logic              shdn_n_i,
  input logic              sink_en_o,
  input logic [CODE_W-1:0] sink_code_o,
  input logic              soft_pd_o,
  input logic              commit,
  input logic [CODE_W-1:0] code_hold,
  input logic              armed,
  input logic              idle
);
  assert_quiet_before_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!sink_en_o && sink_code_o == '0));

  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_pull_o);

  assert_code_moves_on_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_hold) |-> $past(commit));

  assert_soft_pd_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_pd_o |-> !sink_en_o);

  assert_shdn_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n_i |-> (!sink_en_o && sink_code_o == '0));

  assert_sda_moves_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_lvl);
endmodule

bind i2c_dac_ctrl i2c_dac_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_lvl    (scl_lvl),
  .sda_pull_o (sda_pull_o),
  .shdn_n_i   (shdn_n_i),
  .sink_en_o  (sink_en_o),
  .sink_code_o(sink_code_o),
  .soft_pd_o  (soft_pd_o),
  .commit     (commit),
  .code_hold  (code_hold),
  .armed      (armed),
  .idle       (idle)
);

// File: tb/i2c_dac_ctrl_bench.sv
module i2c_dac_ctrl_bench;
  localparam int Q = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       shdn_n = 1'b1;
  logic       sda_pull;
  logic       sink_en;
  logic [9:0] sink_code;
  logic       soft_pd;
  logic       sda_line;
  int         checks = 0;
  int         errors = 0;
  int         r12_viol = 0;
  logic       prev_pull = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  i2c_dac_ctrl u_i2c_dac_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .shdn_n_i   (shdn_n),
    .sink_en_o  (sink_en),
    .sink_code_o(sink_code),
    .soft_pd_o  (soft_pd)
  );

  // R12 monitor: pull must not move while the bench holds SCL high
  always @(negedge clk) begin
    if (rst_n && sda_pull != prev_pull && scl_m) r12_viol++;
    prev_pull <= sda_pull;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, input bit glitch, output logic seen);
    wait_cyc(Q);
    sda_m = b;
    wait_cyc(Q / 2);
    if (glitch) begin
      scl_m = 1'b1;
      wait_cyc(2);
      scl_m = 1'b0;
    end
    wait_cyc(Q / 2);
    scl_m = 1'b1;
    wait_cyc(Q);
    seen = sda_line;
    wait_cyc(Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1;
    wait_cyc(Q);
    scl_m = 1'b1;
    wait_cyc(Q);
    sda_m = 1'b0;
    wait_cyc(Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_cyc(Q);
    sda_m = 1'b0;
    wait_cyc(Q);
    scl_m = 1'b1;
    wait_cyc(Q);
    sda_m = 1'b1;
    wait_cyc(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit glitch, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], glitch, s);
    clk_bit(1'b1, glitch, s);
    acked = !s;
  endtask

  task automatic recv_byte(input bit master_ack, output logic [7:0] v);
    logic s;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, 1'b0, s);
      v = {v[6:0], s};
    end
    clk_bit(!master_ack, 1'b0, s);
  endtask

  task automatic write_frame(input logic [7:0] a, input logic [7:0] hi, input logic [7:0] lo,
                             input bit glitch, output bit k0, output bit k1, output bit k2);
    bus_start();
    send_byte(a, glitch, k0);
    send_byte(hi, glitch, k1);
    send_byte(lo, glitch, k2);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 sink_en", sink_en, 0);
    chk("R1 sink_code", sink_code, 0);
    chk("R1 soft_pd", soft_pd, 0);
    chk("R1 sda_pull", sda_pull, 0);
  endtask

  task automatic t_write_basic();
    bit k0, k1, k2;
    write_frame(8'h18, 8'h6A, 8'hBF, 1'b0, k0, k1, k2);
    chk("R2 addr ack", k0, 1);
    chk("R4 hi ack", k1, 1);
    chk("R4 lo ack", k2, 1);
    chk("R4 code", sink_code, 10'h2AB);
    chk("R8 enable", sink_en, 1);
  endtask

  task automatic t_alias();
    bit k0, k1, k2;
    write_frame(8'h1E, 8'h15, 8'h50, 1'b0, k0, k1, k2);
    chk("R2 alias ack", k0, 1);
    chk("R2 alias code", sink_code, 10'h155);
  endtask

  task automatic t_mismatch();
    bit k0, k1, k2;
    write_frame(8'h30, 8'h00, 8'h00, 1'b0, k0, k1, k2);
    chk("R3 no addr ack", k0, 0);
    chk("R3 no data ack", k1 | k2, 0);
    chk("R3 code kept", sink_code, 10'h155);
  endtask

  task automatic t_soft_pd();
    bit k0, k1, k2;
    write_frame(8'h18, 8'h95, 8'h50, 1'b0, k0, k1, k2);
    chk("R8 pd flag", soft_pd, 1);
    chk("R8 pd disables", sink_en, 0);
    chk("R8 pd code zero", sink_code, 0);
    write_frame(8'h18, 8'h15, 8'h50, 1'b0, k0, k1, k2);
    chk("R8 pd cleared", sink_en, 1);
  endtask

  task automatic t_shutdown();
    @(negedge clk);
    shdn_n = 1'b0;
    #2;
    chk("R9 shdn enable", sink_en, 0);
    chk("R9 shdn code", sink_code, 0);
    @(negedge clk);
    shdn_n = 1'b1;
    #2;
    chk("R9 code restored", sink_code, 10'h155);
  endtask

  task automatic t_read();
    bit k0;
    logic [7:0] b0, b1;
    bus_start();
    send_byte(8'h19, 1'b0, k0);
    recv_byte(1'b1, b0);
    recv_byte(1'b0, b1);
    bus_stop();
    chk("R6 read ack", k0, 1);
    chk("R6 read hi", b0, 8'h15);
    chk("R6 read lo", b1, 8'h50);
    bus_start();
    send_byte(8'h19, 1'b0, k0);
    recv_byte(1'b1, b0);
    recv_byte(1'b0, b1);
    bus_stop();
    chk("R6 cleared", {b0, b1}, 16'h0000);
    chk("R6 code kept", sink_code, 10'h155);
  endtask

  task automatic t_abort_stop();
    bit k0, k1;
    logic s;
    bus_start();
    send_byte(8'h18, 1'b0, k0);
    send_byte(8'h3F, 1'b0, k1);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, 1'b0, s);
    bus_stop();
    chk("R5 stop abort code", sink_code, 10'h155);
    chk("R5 stop abort pd", soft_pd, 0);
  endtask

  task automatic t_restart();
    bit k0, k1, k2;
    logic s;
    bus_start();
    send_byte(8'h18, 1'b0, k0);
    for (int i = 0; i < 3; i++) clk_bit(1'b1, 1'b0, s);
    write_frame(8'h18, 8'h3C, 8'h70, 1'b0, k0, k1, k2);
    chk("R5 restart ack", k0, 1);
    chk("R5 restart code", sink_code, 10'h3C7);
  endtask

  task automatic t_glitch();
    bit k0, k1, k2;
    write_frame(8'h18, 8'h0F, 8'h00, 1'b1, k0, k1, k2);
    chk("R10 glitch acks", {k0, k1, k2}, 3'b111);
    chk("R10 glitch code", sink_code, 10'h0F0);
  endtask

  task automatic t_nack_first();
    bit k0;
    logic [7:0] b0, b1;
    bus_start();
    send_byte(8'h19, 1'b0, k0);
    recv_byte(1'b0, b0);
    wait_cyc(Q);
    chk("R7 released", sda_pull, 0);
    bus_stop();
    chk("R7 first byte", b0, 8'h0F);
    bus_start();
    send_byte(8'h19, 1'b0, k0);
    recv_byte(1'b1, b0);
    recv_byte(1'b0, b1);
    bus_stop();
    chk("R7 not cleared", {b0, b1}, 16'h0F00);
  endtask

  task automatic t_extra();
    bit k0, k1, k2, k3;
    bus_start();
    send_byte(8'h18, 1'b0, k0);
    send_byte(8'h2A, 1'b0, k1);
    send_byte(8'h30, 1'b0, k2);
    send_byte(8'hFF, 1'b0, k3);
    bus_stop();
    chk("R11 two acks", {k1, k2}, 2'b11);
    chk("R11 extra nack", k3, 0);
    chk("R11 code", sink_code, 10'h2A3);
  endtask

  bit done = 1'b0;

  initial begin
    wait_cyc(10);
    rst_n = 1'b1;
    wait_cyc(10);
    t_reset();
    t_write_basic();
    t_alias();
    t_mismatch();
    t_soft_pd();
    t_shutdown();
    t_read();
    t_abort_stop();
    t_restart();
    t_glitch();
    t_nack_first();
    t_extra();
    chk("R12 pull timing", r12_viol, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule